// File: doc/BRIEF.md
# Hertz-Programmed Sine Synthesizer

This block is a direct digital synthesizer that turns three plain-number settings into a stream of signed 16-bit sine samples. Software writes the tone frequency in whole hertz, the peak level in DAC codes and a phase shift in signed whole degrees. The block itself turns hertz into a 32-bit phase step and degrees into a 32-bit phase offset. A 15 MS/s sample strobe from the converter side paces the output.

On every sample strobe the three settings are captured together. A phase accumulator advances by the step. The sum of accumulator and offset addresses a full-wave sine that is folded out of a quarter-wave table. That value is multiplied by the level and saturated. A valid pulse marks each new sample a fixed number of clocks after its strobe.

Top module: `hz_sine_synth`

## Requirements
- R1: A synchronous reset, active high, clears `sampleOut` and `sampleValid` to 0 and the phase accumulator to 0. The first sample after reset therefore uses the phase offset alone.
- R2: The phase step is floor(F × K / 2^24), where K = round(2^56 / 15,000,000) and F is the clamped frequency. After each sample the 32-bit accumulator grows by the step that sample captured, wrapping modulo 2^32. Sample n uses the phase (accumulator + offset) mod 2^32.
- R3: A `freqReg` value above 1,000,000 is treated as exactly 1,000,000. All 32 bits of `freqReg` are compared.
- R4: Degrees are read as bits [9:0] of `phaseReg` in two's complement, and bits [31:10] are ignored. The value is reduced modulo 360 to d in 0..359, and the offset is floor(d × M / 2^16) with M = round(2^48 / 360). Settings of -360 and +360 give the same output as 0.
- R5: The sine value is round(32767 × sin(2π(a + 0.5)/1024)), within ±1, where a is bits [31:22] of the sample's phase.
- R6: The level is bits [15:0] of `ampReg`, unsigned, and bits [31:16] are ignored. The output is floor(sine × level / 2^15), within ±1, saturated to -32768..32767. A level of 0 gives 0.
- R7: Settings are sampled only at the clock edge where `sampleTick` is high. Changes to the inputs at any other time affect no sample. With `sampleTick` low the accumulator does not move.
- R8: `sampleValid` is high for exactly one cycle, in the cycle after the third clock edge that follows the edge at which `sampleTick` was sampled high. `sampleOut` changes only in that cycle and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | One-cycle strobe per output sample (converter rate) |
| freqReg | input | 32 | Tone frequency in hertz |
| ampReg | input | 32 | Peak level in DAC codes, low 16 bits |
| phaseReg | input | 32 | Phase shift in degrees, low 10 bits signed |
| sampleOut | output | 16 | Signed sine sample |
| sampleValid | output | 1 | High for one cycle when `sampleOut` is new |

## Verification
The assertions assume that `sampleTick` is low for as long as reset is held, and that reset is asserted at time zero. They also assume that the settings are meaningful only in the cycle in which a strobe is sampled.

The stimulus redraws all three setting words in every cycle, with junk in the unused upper bits. Strobes land on about half the cycles, sometimes back to back and sometimes with gaps. The expected sample is computed from the inputs present at the strobe edge. Directed runs cover the frequency clamp, the ±360 degree wrap, a zero level and saturation at both ends.

// File: rtl/hzs_pkg.sv
package hzs_pkg;
  parameter int ACC_W = 32;
  parameter int AMP_W = 16;
  parameter int REG_W = 32;

  typedef struct packed {
    logic advance;
    logic lookup;
    logic scale;
  } hzs_strobe_t;

  typedef struct packed {
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] off;
    logic [AMP_W-1:0] amp;
  } hzs_setting_t;
endpackage

// File: rtl/hzs_ctrl.sv
module hzs_ctrl
  import hzs_pkg::*;
#(
  parameter int SAMPLE_RATE = 15000000,
  parameter int FREQ_MAX    = 1000000,
  parameter int DEG_W       = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleTick,
  input  logic [REG_W-1:0]   freqReg,
  input  logic [REG_W-1:0]   ampReg,
  input  logic [REG_W-1:0]   phaseReg,
  output hzs_setting_t       settings,
  output hzs_strobe_t        stb
);
  localparam int FreqShift = 24;
  localparam int DegShift  = 16;
  localparam int NormW     = $clog2(360);
  localparam logic [63:0] FreqMul =
    ((64'd1 << (ACC_W + FreqShift)) + 64'(SAMPLE_RATE / 2)) / 64'(SAMPLE_RATE);
  localparam logic [63:0] DegMul = ((64'd1 << (ACC_W + DegShift)) + 64'd180) / 64'd360;
  localparam logic [ACC_W-1:0] IncCap = ACC_W'((64'(FREQ_MAX) * FreqMul) >> FreqShift);

  logic [REG_W-1:0]          freqClamped;
  logic signed [DEG_W+1:0]   degWork;
  logic [NormW-1:0]          degNorm;
  hzs_setting_t              nextSet;
  logic [2:0]                tickPipe;
  logic                      unusedHigh;

  assign unusedHigh = ^{ampReg[REG_W-1:AMP_W], phaseReg[REG_W-1:DEG_W]};

  always_comb begin
    freqClamped = (freqReg > REG_W'(FREQ_MAX)) ? REG_W'(FREQ_MAX) : freqReg;
    degWork = {{2{phaseReg[DEG_W-1]}}, phaseReg[DEG_W-1:0]};
    if (degWork >= $signed((DEG_W+2)'(360))) degWork = degWork - $signed((DEG_W+2)'(360));
    if (degWork < $signed((DEG_W+2)'(0)))    degWork = degWork + $signed((DEG_W+2)'(360));
    if (degWork < $signed((DEG_W+2)'(0)))    degWork = degWork + $signed((DEG_W+2)'(360));
    degNorm = degWork[NormW-1:0];
    nextSet.inc = ACC_W'((64'(freqClamped) * FreqMul) >> FreqShift);
    nextSet.off = ACC_W'((64'(degNorm) * DegMul) >> DegShift);
    nextSet.amp = ampReg[AMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settings <= '0;
      tickPipe <= '0;
    end else begin
      if (sampleTick) settings <= nextSet;
      tickPipe <= {tickPipe[1:0], sampleTick};
    end
  end

  assign stb.advance = tickPipe[0];
  assign stb.lookup  = tickPipe[1];
  assign stb.scale   = tickPipe[2];

  p_inc_cap_r3: assert property (@(posedge clk) disable iff (rst)
    settings.inc <= IncCap);

  p_deg_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    degWork >= 0 && degWork < 360);
endmodule

// File: rtl/hzs_quarter_rom.sv
module hzs_quarter_rom #(
  parameter int LUT_BITS = 8,
  parameter int OUT_W    = 16
) (
  input  logic [LUT_BITS-1:0] idx,
  output logic [OUT_W-2:0]    value
);
  localparam int Entries = 1 << LUT_BITS;
  localparam longint Peak = (longint'(1) << (OUT_W - 1)) - 1;

  function automatic logic [OUT_W-2:0] quarterSine(input int k);
    longint x, x2, term, sum, scaled;
    x = ((2 * longint'(k) + 1) * 64'sd1686629713) / (2 * longint'(Entries));
    x2 = (x * x) >>> 30;
    term = x;
    sum = x;
    for (int n = 1; n <= 5; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum = sum + term;
    end
    scaled = (sum * Peak + (longint'(1) << 29)) >>> 30;
    if (scaled > Peak) scaled = Peak;
    if (scaled < 0) scaled = 0;
    return (OUT_W-1)'(scaled);
  endfunction

  logic [OUT_W-2:0] romTable [Entries];

  for (genvar k = 0; k < Entries; k++) begin : g_entry
    assign romTable[k] = quarterSine(k);
  end

  assign value = romTable[idx];
endmodule

// File: rtl/hzs_datapath.sv
module hzs_datapath
  import hzs_pkg::*;
#(
  parameter int LUT_BITS = 8,
  parameter int OUT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  hzs_setting_t            settings,
  input  hzs_strobe_t             stb,
  output logic signed [OUT_W-1:0] sampleOut,
  output logic                    sampleValid
);
  localparam int AddrW = LUT_BITS + 2;
  localparam int ProdW = OUT_W + AMP_W + 1;

  logic [ACC_W-1:0]          phaseAcc;
  logic [AddrW-1:0]          phaseAddr;
  logic [1:0]                s2Quad;
  logic [LUT_BITS-1:0]       s2Idx;
  logic [AMP_W-1:0]          s2Amp, s3Amp;
  logic [LUT_BITS-1:0]       romIdx;
  logic [OUT_W-2:0]          romVal;
  logic signed [OUT_W-1:0]   romExt, s3Sine;
  logic signed [ProdW-1:0]   sineExt, ampExt, product, shifted;
  logic signed [OUT_W-1:0]   scaled;

  assign phaseAddr = AddrW'((phaseAcc + settings.off) >> (ACC_W - AddrW));
  assign romIdx = s2Quad[0] ? ~s2Idx : s2Idx;
  assign romExt = {1'b0, romVal};

  hzs_quarter_rom #(.LUT_BITS(LUT_BITS), .OUT_W(OUT_W)) u_rom (
    .idx   (romIdx),
    .value (romVal)
  );

  always_comb begin
    sineExt = ProdW'(s3Sine);
    ampExt  = ProdW'(s3Amp);
    product = sineExt * ampExt;
    shifted = product >>> (OUT_W - 1);
    if (shifted[ProdW-1:OUT_W-1] == '0 || shifted[ProdW-1:OUT_W-1] == '1)
      scaled = shifted[OUT_W-1:0];
    else if (shifted[ProdW-1])
      scaled = {1'b1, {(OUT_W-1){1'b0}}};
    else
      scaled = {1'b0, {(OUT_W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc    <= '0;
      s2Quad      <= '0;
      s2Idx       <= '0;
      s2Amp       <= '0;
      s3Amp       <= '0;
      s3Sine      <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (stb.advance) begin
        s2Quad   <= phaseAddr[AddrW-1 -: 2];
        s2Idx    <= phaseAddr[LUT_BITS-1:0];
        s2Amp    <= settings.amp;
        phaseAcc <= phaseAcc + settings.inc;
      end
      if (stb.lookup) begin
        s3Sine <= s2Quad[1] ? -romExt : romExt;
        s3Amp  <= s2Amp;
      end
      if (stb.scale) sampleOut <= scaled;
      sampleValid <= stb.scale;
    end
  end

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stb.advance |=> $stable(phaseAcc));

  p_lower_half_sign_r5: assert property (@(posedge clk) disable iff (rst)
    stb.lookup && s2Quad[1] |=> s3Sine <= 0);

  p_zero_level_r6: assert property (@(posedge clk) disable iff (rst)
    stb.scale && s3Amp == '0 |=> sampleOut == '0);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stb.scale |=> $stable(sampleOut));
endmodule

// File: rtl/hz_sine_synth.sv
module hz_sine_synth
  import hzs_pkg::*;
#(
  parameter int SAMPLE_RATE = 15000000,
  parameter int FREQ_MAX    = 1000000,
  parameter int LUT_BITS    = 8,
  parameter int OUT_W       = 16,
  parameter int DEG_W       = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleTick,
  input  logic [31:0]             freqReg,
  input  logic [31:0]             ampReg,
  input  logic [31:0]             phaseReg,
  output logic signed [OUT_W-1:0] sampleOut,
  output logic                    sampleValid
);
  hzs_setting_t settings;
  hzs_strobe_t  stb;

  hzs_ctrl #(.SAMPLE_RATE(SAMPLE_RATE), .FREQ_MAX(FREQ_MAX), .DEG_W(DEG_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleTick (sampleTick),
    .freqReg    (freqReg),
    .ampReg     (ampReg),
    .phaseReg   (phaseReg),
    .settings   (settings),
    .stb        (stb)
  );

  hzs_datapath #(.LUT_BITS(LUT_BITS), .OUT_W(OUT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .settings    (settings),
    .stb         (stb),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sampleValid && sampleOut == '0);

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    sampleTick |-> ##4 sampleValid);
endmodule

// File: tb/hz_sine_synth_test.sv
module hz_sine_synth_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleTick = 1'b0;
  logic [31:0] freqReg = '0, ampReg = '0, phaseReg = '0;
  logic signed [15:0] sampleOut;
  logic sampleValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  longint unsigned modelAcc = 0;
  longint expQ[$];
  string tagQ[$];
  logic [3:0] hist;
  logic signed [15:0] prevOut;
  string curTag = "R2";

  always #4 clk = ~clk;

  hz_sine_synth uut (
    .clk(clk), .rst(rst), .sampleTick(sampleTick),
    .freqReg(freqReg), .ampReg(ampReg), .phaseReg(phaseReg),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  function automatic longint unsigned stepOf(input logic [31:0] f);
    longint unsigned fc, k;
    fc = (f > 32'd1000000) ? 64'd1000000 : 64'(f);
    k = ((64'd1 << 56) + 64'd7500000) / 64'd15000000;
    return ((fc * k) >> 24) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint unsigned offsetOf(input logic [31:0] p);
    longint d;
    longint unsigned m;
    d = longint'($signed(p[9:0]));
    d = ((d % 360) + 360) % 360;
    m = ((64'd1 << 48) + 64'd180) / 64'd360;
    return ((longint'(d) * m) >> 16) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint expectedSample(input longint unsigned ph, input logic [31:0] a);
    longint unsigned addr;
    longint s, v;
    real ang;
    addr = (ph & 64'hFFFF_FFFF) >> 22;
    ang = 2.0 * 3.14159265358979 * (real'(addr) + 0.5) / 1024.0;
    s = longint'(int'(32767.0 * $sin(ang)));
    v = (s * longint'(a[15:0])) >>> 15;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp, input longint tol);
    longint diff;
    checks++;
    diff = act - exp;
    if (diff < 0) diff = -diff;
    if (diff > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] f, input logic [31:0] a, input logic [31:0] p, input bit t);
    @(negedge clk);
    freqReg = f; ampReg = a; phaseReg = p; sampleTick = t;
    if (t) begin
      expQ.push_back(expectedSample(modelAcc + offsetOf(p), a));
      tagQ.push_back(curTag);
      modelAcc = (modelAcc + stepOf(f)) & 64'hFFFF_FFFF;
    end
  endtask

  task automatic flush();
    drive(freqReg, ampReg, phaseReg, 1'b0);
    repeat (8) @(negedge clk);
    sampleTick = 1'b0;
    check("R8", longint'(expQ.size()), 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sampleTick = 1'b0;
    modelAcc = 0;
    repeat (3) @(negedge clk);
    check("R1", longint'(sampleOut), 0, 0);
    check("R1", longint'(sampleValid), 0, 0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst) hist <= '0;
    else hist <= {hist[2:0], sampleTick};
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (sampleValid !== hist[3]) begin
        checks++; failures++;
        $display("FAIL R8 valid actual=%0d expected=%0d", sampleValid, hist[3]);
      end
      if (sampleValid) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R8 unexpected sample actual=%0d expected=none", sampleOut);
        end else begin
          check(tagQ.pop_front(), longint'(sampleOut), expQ.pop_front(), 1);
        end
      end else if (sampleOut !== prevOut) begin
        checks++; failures++;
        $display("FAIL R8 held output actual=%0d expected=%0d", sampleOut, prevOut);
      end
    end
    prevOut = sampleOut;
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'd91817);
    repeat (3) @(negedge clk);
    check("R1", longint'(sampleOut), 0, 0);
    check("R1", longint'(sampleValid), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", longint'(sampleValid), 0, 0);

    // R1: first sample uses offset only
    curTag = "R1";
    drive(32'd123456, 32'd32767, 32'd45, 1'b1);
    drive(32'd123456, 32'd32767, 32'd45, 1'b0);
    flush();

    // R2 and R5: steady tone, back-to-back strobes
    curTag = "R2";
    for (int i = 0; i < 60; i++) drive(32'd250000, 32'd32767, 32'd0, 1'b1);
    curTag = "R5";
    for (int i = 0; i < 60; i++) drive(32'd999999, 32'd20000, 32'd17, 1'b1);
    flush();

    // R3: above-limit frequency values
    curTag = "R3";
    for (int i = 0; i < 20; i++) begin
      drive(32'hFFFF_FFFF, 32'd30000, 32'd0, 1'b1);
      drive(32'd1000001, 32'd30000, 32'd0, (i % 2) == 0);
    end
    flush();

    // R4: degree wrap, with garbage in upper bits
    doReset();
    curTag = "R4";
    drive(32'd0, 32'd32767, 32'd360, 1'b1);
    drive(32'd0, 32'd32767, 32'hFFFF_FE98, 1'b1);
    drive(32'd0, 32'd32767, 32'hABCD_0000, 1'b1);
    drive(32'd0, 32'd32767, 32'd90, 1'b1);
    drive(32'd0, 32'd32767, 32'hFFFF_FF4C, 1'b1);
    drive(32'd0, 32'd32767, 32'h0000_0200, 1'b1);
    drive(32'd0, 32'd32767, 32'd511, 1'b1);
    flush();

    // R6: saturation both ways, zero level, junk upper bits
    curTag = "R6";
    drive(32'd0, 32'hFFFF_FFFF, 32'd90, 1'b1);
    drive(32'd0, 32'h0001_FFFF, 32'd270, 1'b1);
    drive(32'd0, 32'h7FFF_0000, 32'd90, 1'b1);
    drive(32'd0, 32'd1, 32'd90, 1'b1);
    drive(32'd0, 32'd40000, 32'd300, 1'b1);
    flush();

    // R7: settings redrawn every cycle, strobes random
    curTag = "R7";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] f, a;
      f = ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 1100000));
      a = ($urandom_range(0, 3) == 0) ? $urandom : {$urandom_range(0, 65535), 16'(32'($urandom_range(0, 32767)))};
      drive(f, a, $urandom, $urandom_range(0, 1) == 1);
      if ((i % 500) == 499) repeat (6) drive($urandom, $urandom, $urandom, 1'b0);
    end
    flush();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule